// File: doc/BRIEF.md
# NCO Phase-Increment Drift Corrector

This block rescales the phase increment of a 64-bit numerically controlled oscillator so that the output frequency stays on target when the oscillator's own clock drifts. A frequency counter elsewhere delivers two numbers for each measurement window: the count the clock should have produced (nominal) and the count it actually produced (measured). The block multiplies the nominal count by the upper 32 bits of the uncorrected increment, divides that 64-bit product by the measured count, and returns the quotient as the upper half of a new 64-bit increment. The lower half is always zero, because the counts carry far more relative error than the lower bits could express.

A fresh correction is needed only every millisecond or so, so the division is done one quotient bit per clock by a restoring shift-subtract divider. A request is accepted with a one-cycle `start_i` pulse while the block is idle. The result, a one-cycle completion pulse and a divide-by-zero flag follow. A measured count of zero is refused at once and leaves the previous increment in place.

Top module: `nco_delta_corrector`

## Requirements
- R1: While `rst_ni` is low, `delta_o` is 0, `done_o` is 0 and `err_o` is 0.
- R2: When `start_i` is high at a rising edge with the block idle and `measured_i` nonzero, the request is accepted. `done_o` is then high for the single cycle that follows the 64th rising edge after the accepting edge.
- R3: When `done_o` rises for an accepted nonzero request, `delta_o[63:32]` equals floor(`nominal_i` × `delta_hi_i` / `measured_i`), using the values present at the accepting edge, provided that quotient is at most 2^32−1.
- R4: `delta_o[31:0]` is always zero.
- R5: If the quotient exceeds 2^32−1, `delta_o[63:32]` saturates to 32'hFFFF_FFFF.
- R6: An accepted request with `measured_i` equal to 0 starts no division. In the cycle after the accepting edge, `done_o` and `err_o` are both 1 and `delta_o` keeps its previous value.
- R7: `err_o` changes only in a cycle where `done_o` is high. It clears to 0 when a nonzero request completes and holds its value otherwise.
- R8: `start_i` is ignored while a division is in progress, including at the edge that ends it. Such a start produces no `done_o` pulse.
- R9: The operands are sampled only at the accepting edge. Later changes to `nominal_i`, `measured_i` or `delta_hi_i` do not alter the result in progress.
- R10: `delta_o` changes only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new correction; honoured only when idle |
| nominal_i | input | 32 | Expected count for the measurement window |
| measured_i | input | 32 | Observed count for the measurement window (divisor) |
| delta_hi_i | input | 32 | Upper 32 bits of the uncorrected increment |
| delta_o | output | 64 | Corrected increment; lower 32 bits zero |
| done_o | output | 1 | One-cycle pulse when a request completes |
| err_o | output | 1 | Last completed request had a zero measured count |

## Verification
Two functions can meet at one clock edge. The first is the last quotient step that raises `done_o`. The second is a new `start_i`, which must be turned away at that edge and accepted only at the next one. The bench holds `start_i` high across whole divisions, with operands changing under it, so that a request is always waiting when a division ends. A zero-divisor request is also issued directly after a completed division, which places two completion pulses in consecutive cycles. A behavioural model in the bench, built from integer countdowns and native 64-bit division, predicts every cycle. `done_o`, `err_o` and both halves of `delta_o` are compared with it on each clock, so one extra or late pulse shows up as a mismatch.

// File: rtl/ncc_pkg.sv
package ncc_pkg;
  localparam int unsigned CNT_W_DEF = 32;
  localparam int unsigned HI_W_DEF  = 32;
  localparam int unsigned INC_W_DEF = 64;
endpackage

// File: rtl/ncc_product.sv
module ncc_product #(
  parameter int unsigned A_W = 32,
  parameter int unsigned B_W = 32,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  always_comb p_o = P_W'(a_i) * P_W'(b_i);
endmodule

// File: rtl/ncc_serial_div.sv
// Restoring divider, one quotient bit per clock, quotient shifts into the dividend register.
module ncc_serial_div #(
  parameter int unsigned N_W = 64,
  parameter int unsigned D_W = 32,
  localparam int unsigned STEP_W = $clog2(N_W) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [N_W-1:0] dividend_i,
  input  logic [D_W-1:0] divisor_i,
  output logic           busy_o,
  output logic           last_o,
  output logic [N_W-1:0] quot_o
);
  logic              busy_q;
  logic [STEP_W-1:0] cnt_q;
  logic [D_W-1:0]    rem_q;
  logic [D_W-1:0]    div_q;
  logic [N_W-1:0]    num_q;

  logic [D_W:0]      rem_sh;
  logic [D_W:0]      rem_sub;
  logic              ge;
  logic [D_W-1:0]    rem_nx;
  logic [N_W-1:0]    num_nx;

  always_comb begin
    rem_sh  = {rem_q, num_q[N_W-1]};
    rem_sub = rem_sh - {1'b0, div_q};
    ge      = rem_sh >= {1'b0, div_q};
    rem_nx  = ge ? rem_sub[D_W-1:0] : rem_sh[D_W-1:0];
    num_nx  = {num_q[N_W-2:0], ge};
  end

  assign last_o = busy_q && (cnt_q == STEP_W'(N_W - 1));
  assign busy_o = busy_q;
  assign quot_o = num_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      num_q  <= '0;
    end else if (busy_q) begin
      rem_q <= rem_nx;
      num_q <= num_nx;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= '0;
      div_q  <= divisor_i;
      num_q  <= dividend_i;
    end
  end
endmodule

// File: rtl/ncc_result.sv
module ncc_result #(
  parameter int unsigned Q_W   = 64,
  parameter int unsigned HI_W  = 32,
  parameter int unsigned INC_W = 64,
  localparam int unsigned LO_W = INC_W - HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  logic             zero_i,
  input  logic [Q_W-1:0]   quot_i,
  output logic [INC_W-1:0] delta_o,
  output logic             done_o,
  output logic             err_o
);
  logic [HI_W-1:0] hi_sat;
  logic            ovf;

  generate
    if (Q_W > HI_W) begin : g_sat
      assign ovf = |quot_i[Q_W-1:HI_W];
    end else begin : g_nosat
      assign ovf = 1'b0;
    end
  endgenerate

  assign hi_sat = ovf ? {HI_W{1'b1}} : quot_i[HI_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delta_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= fin_i | zero_i;
      if (fin_i) begin
        delta_o <= {hi_sat, {LO_W{1'b0}}};
        err_o   <= 1'b0;
      end else if (zero_i) begin
        err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nco_delta_corrector.sv
module nco_delta_corrector #(
  parameter int unsigned CNT_W = ncc_pkg::CNT_W_DEF,
  parameter int unsigned HI_W  = ncc_pkg::HI_W_DEF,
  parameter int unsigned INC_W = ncc_pkg::INC_W_DEF,
  localparam int unsigned PROD_W = CNT_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nominal_i,
  input  logic [CNT_W-1:0] measured_i,
  input  logic [HI_W-1:0]  delta_hi_i,
  output logic [INC_W-1:0] delta_o,
  output logic             done_o,
  output logic             err_o
);
  logic              busy;
  logic              last;
  logic              accept;
  logic              zero_hit;
  logic              load;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  assign accept   = start_i && !busy;
  assign zero_hit = accept && (measured_i == '0);
  assign load     = accept && (measured_i != '0);

  ncc_product #(.A_W(CNT_W), .B_W(HI_W)) u_prod (
    .a_i(nominal_i), .b_i(delta_hi_i), .p_o(prod)
  );

  ncc_serial_div #(.N_W(PROD_W), .D_W(CNT_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .dividend_i(prod), .divisor_i(measured_i),
    .busy_o(busy), .last_o(last), .quot_o(quot)
  );

  ncc_result #(.Q_W(PROD_W), .HI_W(HI_W), .INC_W(INC_W)) u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .fin_i(last), .zero_i(zero_hit),
    .quot_i(quot), .delta_o(delta_o), .done_o(done_o), .err_o(err_o)
  );
endmodule

// File: rtl/nco_delta_corrector_chk.sv
module nco_delta_corrector_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 64,
  parameter int unsigned LO_W  = 32,
  parameter int unsigned LAT   = 65
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] measured_i,
  input logic             busy_i,
  input logic [INC_W-1:0] delta_o,
  input logic             done_o,
  input logic             err_o
);
  logic [7:0] win_q;
  logic       acc_nz;
  logic       acc_z;

  assign acc_nz = start_i && !busy_i && (measured_i != '0);
  assign acc_z  = start_i && !busy_i && (measured_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      win_q <= '0;
    else if (win_q == 8'(LAT))        win_q <= '0;
    else if (win_q != '0)             win_q <= win_q + 1'b1;
    else if (acc_nz)                  win_q <= 8'd1;
  end

  a_r4_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta_o[LO_W-1:0] == '0);
  a_r10_delta_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(delta_o));
  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o));
  a_r6_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_z |=> (done_o && err_o));
  a_r6_keep_delta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> $stable(delta_o));
  a_r2_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_nz |=> !done_o);
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == 8'(LAT)) |-> (done_o && !err_o));
  a_r8_busy_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i && (measured_i == '0)) |=> !err_o || $stable(err_o));
endmodule

bind nco_delta_corrector nco_delta_corrector_chk #(
  .CNT_W(CNT_W), .INC_W(INC_W), .LO_W(INC_W - HI_W), .LAT(PROD_W + 1)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .measured_i(measured_i),
  .busy_i(busy), .delta_o(delta_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/nco_delta_corrector_bench.sv
`timescale 1ns/1ps
module nco_delta_corrector_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] nominal_i = '0;
  logic [31:0] measured_i = '0;
  logic [31:0] delta_hi_i = '0;
  logic [63:0] delta_o;
  logic        done_o;
  logic        err_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_cyc = 0;

  always #2 clk_i = ~clk_i;

  nco_delta_corrector u_nco_delta_corrector (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .nominal_i(nominal_i), .measured_i(measured_i), .delta_hi_i(delta_hi_i),
    .delta_o(delta_o), .done_o(done_o), .err_o(err_o)
  );

  // behavioural reference
  bit              m_busy = 0;
  int              m_left = 0;
  longint unsigned m_prod = 0;
  longint unsigned m_meas = 0;
  logic [63:0]     m_delta = '0;
  bit              m_done = 0;
  bit              m_err = 0;

  function automatic logic [31:0] exp_hi(longint unsigned nom, longint unsigned meas,
                                         longint unsigned dh);
    longint unsigned q;
    q = (nom * dh) / meas;
    return (q > 64'h0000_0000_FFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_left = 0; m_delta = '0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0;
          m_delta = {exp_hi(m_prod, m_meas, 1), 32'h0};
          m_done = 1;
          m_err = 0;
        end
      end else if (start_i) begin
        if (measured_i == 0) begin
          m_done = 1; m_err = 1;
        end else begin
          m_busy = 1; m_left = 64;
          m_prod = longint'(nominal_i) * longint'(delta_hi_i);
          m_meas = longint'(measured_i);
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    n_cyc++;
    chk(done_o == m_done, "R2 done", 64'(done_o), 64'(m_done));
    chk(err_o == m_err, "R7 err", 64'(err_o), 64'(m_err));
    chk(delta_o[31:0] == 32'h0, "R4 low half", 64'(delta_o[31:0]), 64'h0);
    chk(delta_o[63:32] == m_delta[63:32], m_done ? "R3 result" : "R10 hold",
        64'(delta_o[63:32]), 64'(m_delta[63:32]));
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<150000", n_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic go(logic [31:0] nom, logic [31:0] meas, logic [31:0] dh);
    @(negedge clk_i);
    nominal_i = nom; measured_i = meas; delta_hi_i = dh; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (m_busy) @(negedge clk_i);
  endtask

  initial begin
    int dones;
    logic [63:0] prev;
    repeat (3) @(negedge clk_i);
    chk(delta_o == 0 && !done_o && !err_o, "R1 reset", delta_o, 64'h0);
    rst_ni = 1'b1;

    go(32'd1_000_000, 32'd999_950, 32'h2000_0000);
    chk(done_o, "R2 pulse", 64'(done_o), 64'h1);
    chk(delta_o[63:32] == exp_hi(1_000_000, 999_950, 32'h2000_0000), "R3 value",
        64'(delta_o[63:32]), 64'(exp_hi(1_000_000, 999_950, 32'h2000_0000)));

    // R6: zero divisor keeps previous increment
    prev = delta_o;
    go(32'd5, 32'd0, 32'd7);
    chk(done_o && err_o, "R6 flag", {err_o, done_o}, 64'h3);
    chk(delta_o == prev, "R6 keep", delta_o, prev);

    // R7: next good request clears the flag
    go(32'd100, 32'd3, 32'd9);
    chk(!err_o && delta_o[63:32] == 32'd300, "R7 clear", delta_o, {32'd300, 32'd0});

    // R5: saturation and its boundary
    go(32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF);
    chk(delta_o[63:32] == 32'hFFFF_FFFF, "R5 sat", delta_o, 64'hFFFF_FFFF_0000_0000);
    go(32'hFFFF_FFFF, 32'd1, 32'd1);
    chk(delta_o[63:32] == 32'hFFFF_FFFF, "R5 edge", delta_o, 64'hFFFF_FFFF_0000_0000);
    go(32'd65536, 32'd1, 32'd65536);
    chk(delta_o[63:32] == 32'hFFFF_FFFF, "R5 2^32", delta_o, 64'hFFFF_FFFF_0000_0000);
    go(32'd7, 32'd8, 32'd1);
    chk(delta_o[63:32] == 32'd0, "R3 zero quotient", delta_o, 64'h0);

    // R8/R9: start held high, operands churning during the division
    @(negedge clk_i);
    nominal_i = 32'd1_600_000; measured_i = 32'd1_599_871; delta_hi_i = 32'h1234_5678;
    start_i = 1'b1;
    dones = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (done_o) dones++;
      nominal_i = 32'(i * 977); measured_i = (i % 3 == 0) ? 32'd0 : 32'(i + 1);
      delta_hi_i = 32'(i * 31);
    end
    start_i = 1'b0;
    chk(dones == 0, "R8 ignored", 64'(dones), 64'h0);
    while (m_busy) @(negedge clk_i);
    chk(delta_o[63:32] == exp_hi(1_600_000, 1_599_871, 32'h1234_5678), "R9 sampled",
        64'(delta_o[63:32]), 64'(exp_hi(1_600_000, 1_599_871, 32'h1234_5678)));

    // back-to-back: start held across completions, then zero right after a finish
    @(negedge clk_i);
    nominal_i = 32'd999; measured_i = 32'd1000; delta_hi_i = 32'hDEAD_BEEF; start_i = 1'b1;
    repeat (200) @(negedge clk_i);
    measured_i = 32'd0;
    while (m_busy) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(done_o && err_o, "R6 repeated zero", {err_o, done_o}, 64'h3);
    start_i = 1'b0;
    @(negedge clk_i);

    for (int k = 0; k < 40; k++) begin
      logic [31:0] nn, mm, dd;
      nn = $urandom; dd = $urandom;
      mm = (k % 4 == 0) ? 32'($urandom % 16) : $urandom;
      go(nn, mm, dd);
      if (mm != 0)
        chk(delta_o[63:32] == exp_hi(nn, mm, dd), "R3 random",
            64'(delta_o[63:32]), 64'(exp_hi(nn, mm, dd)));
    end

    repeat (4) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule